// File: doc/BRIEF.md
# Multi-Port Fan PWM Generator

This block drives up to eight fan control outputs from one system clock. Three independent timebases each run a prescaler and a period counter. Every output port picks one timebase and compares that timebase's count against its own pair of edge points: the output rises when the count reaches the rise point and drops when it reaches the fall point. A rise point above the fall point wraps the high phase across the period boundary. Software programs the block through a plain write port and reads nothing back.

Each timebase is a two-state machine. TB_IDLE holds the prescaler and the counter at zero. The transition TB_IDLE to TB_RUN is taken when the global run bit is set, and TB_RUN to TB_IDLE is taken when it is cleared. Each port is a three-state machine. PO_OFF drives low and is entered from any state when the port is disabled, the global run bit is clear, or the type code is reserved. From any state an active port goes to PO_HIGH when its compare window covers the selected count, and to PO_LOW otherwise. Edge points pass into a per-port shadow copy only at the wrap of the selected counter, or while the port is off.

Register words, indexed by `wr_addr`: word 0 is control, words 1 to 3 configure timebases 0 to 2, and words 4 to 7 hold the edge points for port pairs (0,1), (2,3), (4,5) and (6,7).

Top module: `fan_pwm_gen`

## Requirements
- R1: Timebase field H (bits 7:4 of words 1 to 3) divides the clock by 2^H.
- R2: Timebase field L (bits 3:0 of the same words) divides by 1 when L is 0 and by 2×L otherwise, in series with the H divider.
- R3: One output period lasts (P + 1) prescaled ticks, P being the 8-bit field in bits 15:8 of the timebase word. With H = 0 and L = 0 a period is P + 1 clock cycles.
- R4: An active port is high for (fall − rise) ticks per period when rise < fall, and for (P + 1 − rise + fall) ticks when rise > fall (high phase wrapping the boundary).
- R5: Equal rise and fall points, including both zero, hold the output high for the whole period.
- R6: A port whose enable bit (control bit 8 + port) is clear drives low, and the other ports keep running.
- R7: The 2-bit type code of a port has its low bit at control bit 16 + port and its high bit at control bit 24 + port. Codes 0, 1, 2 select timebases 0, 1, 2; code 3 holds the port low.
- R8: In a pair word the even port takes its rise point from bits 7:0 and its fall point from bits 15:8, and the odd port takes rise from bits 23:16 and fall from bits 31:24.
- R9: While the global run bit (control bit 0) is clear no counter advances and every output is low.
- R10: New edge points written while a port runs take effect at the next wrap of its timebase counter, so the high phase in progress keeps its old length.
- R11: After synchronous reset every output is low and all configuration is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register word index |
| wr_data | input | 32 | Write data |
| pwm_out | output | 8 | Fan PWM outputs, one bit per port |

## Verification
The two functions that can coincide are a software write of new edge points and the period wrap that reloads the shadow copy. The bench waits for a rising output edge, writes a longer fall point two cycles into the high phase, and judges by counting the remaining high cycles of that phase (old length) and the full length of the next phase (new length). A design that applies the write at once or misses the reload gives a different count in one of the two phases.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

    localparam int L_W   = 4;
    localparam int H_W   = 4;
    localparam int CNT_W = 8;
    localparam int PT_W  = 8;

    // Timebase configuration word, low 16 bits of words 1..3
    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [H_W-1:0]   h_div;
        logic [L_W-1:0]   l_div;
    } tb_cfg_t;

    // Edge points of one port, one half of a pair word
    typedef struct packed {
        logic [PT_W-1:0] fall;
        logic [PT_W-1:0] rise;
    } edge_pts_t;

    typedef enum logic {
        TB_IDLE,
        TB_RUN
    } tb_state_t;

    typedef enum logic [1:0] {
        PO_OFF,
        PO_LOW,
        PO_HIGH
    } port_state_t;

endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
    import fan_pwm_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int NUM_TYPES = 3,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 32
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic                                run_o,
    output logic [NUM_PORTS-1:0]                port_en_o,
    output logic [NUM_PORTS-1:0][1:0]           port_type_o,
    output tb_cfg_t [NUM_TYPES-1:0]             cfg_o,
    output edge_pts_t [NUM_PORTS-1:0]           pts_o
);

    localparam int NUM_PAIRS = (NUM_PORTS + 1) / 2;
    localparam int PAIR_BASE = 1 + NUM_TYPES;
    localparam int EN_LSB    = 8;
    localparam int TLO_LSB   = 16;
    localparam int THI_LSB   = 24;
    localparam int HALF_W    = $bits(edge_pts_t);

    logic                              run_q;
    logic [NUM_PORTS-1:0]              en_q;
    logic [NUM_PORTS-1:0]              tlo_q;
    logic [NUM_PORTS-1:0]              thi_q;
    tb_cfg_t [NUM_TYPES-1:0]           cfg_q;
    logic [NUM_PAIRS-1:0][DATA_W-1:0]  pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            en_q   <= '0;
            tlo_q  <= '0;
            thi_q  <= '0;
            cfg_q  <= '0;
            pair_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == '0) begin
                run_q <= wr_data[0];
                en_q  <= wr_data[EN_LSB  +: NUM_PORTS];
                tlo_q <= wr_data[TLO_LSB +: NUM_PORTS];
                thi_q <= wr_data[THI_LSB +: NUM_PORTS];
            end
            for (int t = 0; t < NUM_TYPES; t++) begin
                if (wr_addr == ADDR_W'(1 + t))
                    cfg_q[t] <= tb_cfg_t'(wr_data[$bits(tb_cfg_t)-1:0]);
            end
            for (int d = 0; d < NUM_PAIRS; d++) begin
                if (wr_addr == ADDR_W'(PAIR_BASE + d))
                    pair_q[d] <= wr_data;
            end
        end
    end

    assign run_o     = run_q;
    assign port_en_o = en_q;
    assign cfg_o     = cfg_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_map
        assign port_type_o[p] = {thi_q[p], tlo_q[p]};
        assign pts_o[p]       = edge_pts_t'(pair_q[p/2][HALF_W*(p%2) +: HALF_W]);
    end

    // R11: configuration is cleared by reset
    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (!run_q && en_q == '0));

endmodule

// File: rtl/fan_pwm_timebase.sv
module fan_pwm_timebase
    import fan_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  tb_cfg_t          cfg_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    // largest divisor is 2*(2^L_W-1) << (2^H_W-1)
    localparam int DIV_W = L_W + 1 + (2**H_W - 1);

    tb_state_t        state_q, state_d;
    logic [DIV_W-1:0] pre_q, pre_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] l_part;
    logic [DIV_W-1:0] divisor;
    logic             tick;

    always_comb begin
        if (cfg_i.l_div == '0)
            l_part = DIV_W'(1);
        else
            l_part = {{(DIV_W-L_W-1){1'b0}}, cfg_i.l_div, 1'b0};
        divisor = l_part << cfg_i.h_div;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TB_IDLE;
            pre_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            pre_q   <= pre_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pre_d   = pre_q;
        cnt_d   = cnt_q;
        tick    = 1'b0;
        wrap_o  = 1'b0;
        unique case (state_q)
            TB_IDLE: begin
                pre_d = '0;
                cnt_d = '0;
                if (run_i)
                    state_d = TB_RUN;
            end
            TB_RUN: begin
                if (!run_i) begin
                    state_d = TB_IDLE;
                    pre_d   = '0;
                    cnt_d   = '0;
                end else begin
                    tick = (pre_q >= divisor - DIV_W'(1));
                    if (tick) begin
                        pre_d = '0;
                        if (cnt_q >= cfg_i.period) begin
                            wrap_o = 1'b1;
                            cnt_d  = '0;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end else begin
                        pre_d = pre_q + DIV_W'(1);
                    end
                end
            end
            default: state_d = TB_IDLE;
        endcase
    end

    assign cnt_o = cnt_q;

    // R3: a wrap always restarts the period count at zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_q == '0));

    // R9: nothing advances while the run bit is clear
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0 && pre_q == '0));

endmodule

// File: rtl/fan_pwm_port.sv
module fan_pwm_port
    import fan_pwm_pkg::*;
#(
    parameter int NUM_TYPES = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             en_i,
    input  logic [1:0]                       type_i,
    input  edge_pts_t                        pts_i,
    input  logic [NUM_TYPES-1:0][CNT_W-1:0]  cnt_i,
    input  logic [NUM_TYPES-1:0]             wrap_i,
    output logic                             pwm_o
);

    port_state_t      state_q, state_d;
    edge_pts_t        shadow_q;
    logic             sel_ok;
    logic [CNT_W-1:0] cnt_sel;
    logic             wrap_sel;
    logic             in_window;
    logic             active;

    always_comb begin
        sel_ok   = 1'b0;
        cnt_sel  = '0;
        wrap_sel = 1'b0;
        for (int t = 0; t < NUM_TYPES; t++) begin
            if (type_i == 2'(t)) begin
                sel_ok   = 1'b1;
                cnt_sel  = cnt_i[t];
                wrap_sel = wrap_i[t];
            end
        end
        active = en_i && sel_ok;
    end

    // shadow edge points: reloaded only at the wrap or while off
    always_ff @(posedge clk) begin
        if (rst)
            shadow_q <= '0;
        else if (!active || wrap_sel)
            shadow_q <= pts_i;
    end

    always_comb begin
        if (shadow_q.rise == shadow_q.fall)
            in_window = 1'b1;
        else if (shadow_q.rise < shadow_q.fall)
            in_window = (cnt_sel >= shadow_q.rise) && (cnt_sel < shadow_q.fall);
        else
            in_window = (cnt_sel >= shadow_q.rise) || (cnt_sel < shadow_q.fall);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PO_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PO_OFF, PO_LOW, PO_HIGH: begin
                if (!active)
                    state_d = PO_OFF;
                else if (in_window)
                    state_d = PO_HIGH;
                else
                    state_d = PO_LOW;
            end
            default: state_d = PO_OFF;
        endcase
    end

    always_comb begin
        pwm_o = (state_q == PO_HIGH);
    end

    // R6: a disabled port is low on the next cycle
    p_off_low_r6: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !pwm_o);

    // R7: a reserved type code holds the port low
    p_reserved_low_r7: assert property (@(posedge clk) disable iff (rst)
        (type_i == 2'b11) |=> !pwm_o);

    // R5: equal edge points give a high output
    p_full_high_r5: assert property (@(posedge clk) disable iff (rst)
        (active && shadow_q.rise == shadow_q.fall) |=> pwm_o);

    // R10: running shadow points change only at a wrap
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (active && !wrap_sel) |=> $stable(shadow_q));

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
    import fan_pwm_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int NUM_TYPES = 3,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [NUM_PORTS-1:0] pwm_out
);

    logic                             run;
    logic [NUM_PORTS-1:0]             port_en;
    logic [NUM_PORTS-1:0][1:0]        port_type;
    tb_cfg_t [NUM_TYPES-1:0]          cfg;
    edge_pts_t [NUM_PORTS-1:0]        pts;
    logic [NUM_TYPES-1:0][CNT_W-1:0]  tb_cnt;
    logic [NUM_TYPES-1:0]             tb_wrap;

    fan_pwm_regs #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_TYPES (NUM_TYPES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .run_o       (run),
        .port_en_o   (port_en),
        .port_type_o (port_type),
        .cfg_o       (cfg),
        .pts_o       (pts)
    );

    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_tb
        fan_pwm_timebase u_tb (
            .clk    (clk),
            .rst    (rst),
            .run_i  (run),
            .cfg_i  (cfg[t]),
            .cnt_o  (tb_cnt[t]),
            .wrap_o (tb_wrap[t])
        );
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        fan_pwm_port #(
            .NUM_TYPES (NUM_TYPES)
        ) u_port (
            .clk    (clk),
            .rst    (rst),
            .en_i   (run && port_en[p]),
            .type_i (port_type[p]),
            .pts_i  (pts[p]),
            .cnt_i  (tb_cnt),
            .wrap_i (tb_wrap),
            .pwm_o  (pwm_out[p])
        );
    end

    // R9: all outputs low one cycle after the run bit is seen clear
    p_run_off_low_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pwm_out == '0));

endmodule

// File: tb/test_fan_pwm_gen.sv
module test_fan_pwm_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  pwm_out;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] ctrl = '0;
    logic [31:0] pair [4];

    always #2.5 clk = ~clk;

    fan_pwm_gen i_fan_pwm_gen (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_tb(input int t, input int h, input int l, input int per);
        wr(3'(1 + t), {16'h0, 8'(per), 4'(h), 4'(l)});
    endtask

    task automatic set_pts(input int p, input int r, input int f);
        pair[p/2][16*(p%2) +: 16] = {8'(f), 8'(r)};
        wr(3'(4 + p/2), pair[p/2]);
    endtask

    task automatic set_port(input int p, input bit en, input int code);
        ctrl[8 + p]  = en;
        ctrl[16 + p] = code[0];
        ctrl[24 + p] = code[1];
        wr(3'd0, ctrl);
    endtask

    task automatic set_run(input bit r);
        ctrl[0] = r;
        wr(3'd0, ctrl);
    endtask

    task automatic settle();
        repeat (80) @(negedge clk);
    endtask

    task automatic count_high(input int p, input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out[p]) hi++;
        end
    endtask

    task automatic wait_rise(input int p, output bit ok);
        logic prev;
        ok = 1'b0;
        prev = pwm_out[p];
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!prev && pwm_out[p]) begin
                ok = 1'b1;
                break;
            end
            prev = pwm_out[p];
        end
    endtask

    task automatic meas_period(input int p, output int per);
        bit ok;
        logic prev;
        per = -1;
        wait_rise(p, ok);
        if (ok) begin
            prev = 1'b1;
            for (int i = 1; i <= 400; i++) begin
                @(negedge clk);
                if (!prev && pwm_out[p]) begin
                    per = i;
                    break;
                end
                prev = pwm_out[p];
            end
        end
    endtask

    task automatic run_length(input int p, output int n);
        n = 0;
        while (pwm_out[p] && n < 400) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 outputs after reset", int'(pwm_out), 0);
    endtask

    task automatic t_run_off();
        int hi;
        set_tb(0, 0, 0, 9);
        set_pts(0, 2, 6);
        set_port(0, 1'b1, 0);
        count_high(0, 40, hi);
        check("R9 run clear keeps output low", hi, 0);
    endtask

    task automatic t_period();
        int per, hi;
        set_run(1'b1);
        settle();
        meas_period(0, per);
        check("R3 period P+1 cycles", per, 10);
        count_high(0, 40, hi);
        check("R4 high fall-rise ticks", hi, 16);
    endtask

    task automatic t_wrap();
        int hi;
        set_pts(0, 7, 3);
        settle();
        count_high(0, 40, hi);
        check("R4 wrapped high phase", hi, 24);
    endtask

    task automatic t_full();
        int hi;
        set_pts(0, 0, 0);
        settle();
        count_high(0, 30, hi);
        check("R5 zero points full duty", hi, 30);
        set_pts(0, 5, 5);
        settle();
        count_high(0, 30, hi);
        check("R5 equal points full duty", hi, 30);
    endtask

    task automatic t_hdiv();
        int per, hi;
        set_tb(1, 2, 0, 3);
        set_pts(1, 1, 3);
        set_port(1, 1'b1, 1);
        settle();
        meas_period(1, per);
        check("R1 H divider period", per, 16);
        count_high(1, 32, hi);
        check("R8 odd port upper half points", hi, 16);
    endtask

    task automatic t_ldiv();
        int per, hi;
        set_tb(2, 0, 3, 4);
        set_pts(2, 0, 2);
        set_port(2, 1'b1, 2);
        settle();
        meas_period(2, per);
        check("R2 L divider period", per, 30);
        count_high(2, 60, hi);
        check("R2 L divider high time", hi, 24);
    endtask

    task automatic t_disable();
        int hi, per;
        set_port(0, 1'b0, 0);
        count_high(0, 30, hi);
        check("R6 disabled port low", hi, 0);
        meas_period(1, per);
        check("R6 other port still runs", per, 16);
    endtask

    task automatic t_reserved();
        int hi;
        set_pts(3, 0, 0);
        set_port(3, 1'b1, 3);
        settle();
        count_high(3, 40, hi);
        check("R7 code 3 holds low", hi, 0);
    endtask

    task automatic t_shadow();
        bit ok;
        int n;
        set_pts(0, 0, 4);
        set_port(0, 1'b1, 0);
        settle();
        wait_rise(0, ok);
        check("R10 rise seen", int'(ok), 1);
        set_pts(0, 0, 7);
        run_length(0, n);
        check("R10 current phase keeps old fall", n, 2);
        wait_rise(0, ok);
        run_length(0, n);
        check("R10 next phase uses new fall", n, 7);
    endtask

    task automatic t_stop();
        int hi;
        set_run(1'b0);
        count_high(1, 40, hi);
        check("R9 run cleared stops port", hi, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) pair[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_run_off();
        t_period();
        t_wrap();
        t_full();
        t_hdiv();
        t_ldiv();
        t_disable();
        t_reserved();
        t_shadow();
        t_stop();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule